// File: doc/BRIEF.md
# Table-Driven Duty-Cycle Compensator

This block closes a digital voltage loop for a switching regulator without a single multiplier. Once per switching period a strobe arrives together with a 12-bit word from a bank of window comparators. The block turns that word into one of thirteen error levels, from −6 to +6. It then computes a new duty-cycle command with a three-tap difference equation. The command is the previous duty plus three coefficient products. Each product is read from a small table indexed by the current error, the previous error or the error before that. No arithmetic beyond addition is performed.

Each table holds one precomputed product per error level. The tables come up from reset holding the default coefficients 1.204, −2.7685 and 1.8546. Through a single-cycle write port they can be reloaded with any other compensator, for example one tuned for a different output filter. The sum is kept in fixed point with 11 fractional bits. It is truncated to a 13-bit integer duty and clamped to the representable range. The modulator downstream consumes `duty_o` when `valid_o` pulses.

The control sequencing is a two-state machine. In `ST_IDLE` the block waits, holding the duty output. A strobe takes the `T_IDLE_TO_PUBLISH` transition and commits the update on that edge. `ST_PUBLISH` drives `valid_o` for exactly one cycle. From there `T_PUBLISH_TO_IDLE` returns to waiting, or `T_PUBLISH_STAY` stays put when a new strobe arrives back to back.

Top module: `pid_lut_comp`

## Requirements
- R1: While `rst_n` is low and after its release, `duty_o` equals parameter `INIT_DUTY` (default 4096) and `valid_o` is 0. Both delayed errors start at the zero-error code 6, so the zero-error entries are the ones used for e[n-1] and e[n-2] on the first update.
- R2: The error code used for an update is the number of set bits in `therm_i`, from 0 to 12, whether or not the word is a contiguous thermometer. Code 6 means zero error, and code k stands for error k−6.
- R3: On a strobe the new duty is floor((d[n-1]·2048 + A[e0] + B[e1] + C[e2]) / 2048), clamped as in R5. Here e0 is the current code, e1 is the code from the previous strobe and e2 is the code from the strobe before that. After the update, e1 takes e0 and e2 takes the old e1.
- R4: Truncation drops the 11 fractional bits toward minus infinity. A sum one LSB below an integer value N gives N−1.
- R5: The result saturates at 0 and 8191 instead of wrapping. The clamped value is what is stored as d[n-1] for the next update.
- R6: `valid_o` is high in exactly the cycle after each strobe cycle and low otherwise. `duty_o` changes only on the clock edge that samples a strobe.
- R7: With `tbl_we` high, entry `tbl_addr` of table `tbl_sel` (0 = A, the current-error tap; 1 = B, the one-delay tap; 2 = C, the two-delay tap) takes the 24-bit signed value `tbl_data` on the next edge. Writes with `tbl_sel` = 3 or `tbl_addr` above 12 change no table.
- R8: After reset, entry k of each table holds round(coef·2048)·(k−6), using the coefficients A = 2466, B = −5670 and C = 3798 in Q.11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | One-cycle pulse per switching period requesting an update |
| therm_i | input | 12 | Window comparator word |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 2 | Table select: 0 = A, 1 = B, 2 = C |
| tbl_addr | input | 4 | Table entry index (0..12) |
| tbl_data | input | 24 | Signed Q.11 entry value |
| duty_o | output | 13 | Duty-cycle command |
| valid_o | output | 1 | One-cycle pulse marking a new duty command |

## Verification
The bound checker watches, on every cycle, the strobe-to-valid pulse timing, the hold of the duty output between strobes, the shift of the error history, and the range of the encoded error code. The arithmetic can only be shown by the bench's scenarios, which compare the duty against a fixed-point reference model. That arithmetic covers the table lookups per tap, floor truncation, clamping at both rails and recovery from them, reloaded tables, ignored writes and non-contiguous comparator words.

// File: rtl/pidlut_pkg.sv
package pidlut_pkg;

    localparam int NCMP      = 12;
    localparam int CODE_W    = 4;
    localparam int DUTY_W    = 13;
    localparam int FRAC_W    = 11;
    localparam int COEF_W    = 24;
    localparam int NTAP      = 3;
    localparam int NLVL      = NCMP + 1;
    localparam int ZERO_CODE = NCMP / 2;
    localparam int SEL_W     = $clog2(NTAP + 1);

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PUBLISH = 1'b1
    } pid_state_e;

    // Product of a Q.11 coefficient with the signed error of a level code.
    function automatic logic [COEF_W-1:0] default_entry(input int coef_q, input int idx);
        int prod;
        prod = coef_q * (idx - ZERO_CODE);
        return COEF_W'(prod);
    endfunction

endpackage

// File: rtl/therm_encoder.sv
module therm_encoder #(
    parameter int N_IN  = pidlut_pkg::NCMP,
    parameter int OUT_W = pidlut_pkg::CODE_W
) (
    input  logic [N_IN-1:0]  word_i,
    output logic [OUT_W-1:0] code_o
);

    // Population count: a broken thermometer still maps to a legal level.
    always_comb begin
        code_o = '0;
        for (int i = 0; i < N_IN; i++) begin
            code_o = code_o + OUT_W'(word_i[i]);
        end
    end

endmodule

// File: rtl/coef_bank.sv
module coef_bank
    import pidlut_pkg::*;
#(
    parameter int NT   = NTAP,
    parameter int NL   = NLVL,
    parameter int CW   = CODE_W,
    parameter int EW   = COEF_W,
    parameter int SW   = SEL_W,
    parameter int CA_Q = 2466,
    parameter int CB_Q = -5670,
    parameter int CC_Q = 3798
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [SW-1:0]        sel_i,
    input  logic [CW-1:0]        addr_i,
    input  logic [EW-1:0]        data_i,
    input  logic [NT-1:0][CW-1:0] idx_i,
    output logic [NT-1:0][EW-1:0] entry_o
);

    logic addr_ok;
    assign addr_ok = (addr_i < CW'(NL));

    for (genvar t = 0; t < NT; t++) begin : g_tap
        localparam int CQ = (t == 0) ? CA_Q : ((t == 1) ? CB_Q : CC_Q);

        logic [EW-1:0] mem [NL];
        logic          hit;

        assign hit = we_i && addr_ok && (sel_i == SW'(t));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < NL; i++) begin
                    mem[i] <= default_entry(CQ, i);
                end
            end else if (hit) begin
                mem[addr_i] <= data_i;
            end
        end

        assign entry_o[t] = (idx_i[t] < CW'(NL)) ? mem[idx_i[t]] : '0;
    end

endmodule

// File: rtl/duty_accum.sv
module duty_accum
    import pidlut_pkg::*;
#(
    parameter int NT = NTAP,
    parameter int DW = DUTY_W,
    parameter int FW = FRAC_W,
    parameter int EW = COEF_W
) (
    input  logic [DW-1:0]         prev_i,
    input  logic [NT-1:0][EW-1:0] entry_i,
    output logic [DW-1:0]         next_o
);

    localparam int SUM_W = DW + FW + 4;

    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] whole;

    always_comb begin
        acc = signed'({{(SUM_W-DW-FW){1'b0}}, prev_i, {FW{1'b0}}});
        for (int t = 0; t < NT; t++) begin
            acc = acc + signed'({{(SUM_W-EW){entry_i[t][EW-1]}}, entry_i[t]});
        end
        whole = acc >>> FW;
        if (whole[SUM_W-1]) begin
            next_o = '0;
        end else if (|whole[SUM_W-2:DW]) begin
            next_o = '1;
        end else begin
            next_o = whole[DW-1:0];
        end
    end

endmodule

// File: rtl/pid_lut_comp.sv
module pid_lut_comp
    import pidlut_pkg::*;
#(
    parameter int INIT_DUTY = 4096,
    parameter int CA_Q      = 2466,
    parameter int CB_Q      = -5670,
    parameter int CC_Q      = 3798
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [NCMP-1:0]   therm_i,
    input  logic              tbl_we,
    input  logic [SEL_W-1:0]  tbl_sel,
    input  logic [CODE_W-1:0] tbl_addr,
    input  logic [COEF_W-1:0] tbl_data,
    output logic [DUTY_W-1:0] duty_o,
    output logic              valid_o
);

    pid_state_e state_q, state_d;

    logic [CODE_W-1:0]             e0_code;
    logic [CODE_W-1:0]             e1_q, e2_q;
    logic [DUTY_W-1:0]             duty_q, duty_next;
    logic [NTAP-1:0][CODE_W-1:0]   tap_idx;
    logic [NTAP-1:0][COEF_W-1:0]   tap_entry;

    therm_encoder #(.N_IN(NCMP), .OUT_W(CODE_W)) u_enc (
        .word_i (therm_i),
        .code_o (e0_code)
    );

    assign tap_idx[0] = e0_code;
    assign tap_idx[1] = e1_q;
    assign tap_idx[2] = e2_q;

    coef_bank #(
        .NT(NTAP), .NL(NLVL), .CW(CODE_W), .EW(COEF_W), .SW(SEL_W),
        .CA_Q(CA_Q), .CB_Q(CB_Q), .CC_Q(CC_Q)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (tbl_we),
        .sel_i   (tbl_sel),
        .addr_i  (tbl_addr),
        .data_i  (tbl_data),
        .idx_i   (tap_idx),
        .entry_o (tap_entry)
    );

    duty_accum #(.NT(NTAP), .DW(DUTY_W), .FW(FRAC_W), .EW(COEF_W)) u_acc (
        .prev_i  (duty_q),
        .entry_i (tap_entry),
        .next_o  (duty_next)
    );

    // History and duty commit on the strobe edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q <= DUTY_W'(INIT_DUTY);
            e1_q   <= CODE_W'(ZERO_CODE);
            e2_q   <= CODE_W'(ZERO_CODE);
        end else if (strobe) begin
            duty_q <= duty_next;
            e1_q   <= e0_code;
            e2_q   <= e1_q;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_IDLE_TO_PUBLISH, T_PUBLISH_STAY, T_PUBLISH_TO_IDLE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = strobe ? ST_PUBLISH : ST_IDLE;
            ST_PUBLISH: state_d = strobe ? ST_PUBLISH : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        valid_o = (state_q == ST_PUBLISH);
        duty_o  = duty_q;
    end

endmodule

// File: rtl/pid_lut_chk.sv
module pid_lut_chk
    import pidlut_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              strobe,
    input logic              valid_o,
    input logic [DUTY_W-1:0] duty_o,
    input logic [CODE_W-1:0] e0_code,
    input logic [CODE_W-1:0] e1_q,
    input logic [CODE_W-1:0] e2_q
);

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> valid_o);

    // R6
    valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(strobe));

    // R6
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(duty_o));

    // R3
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (e1_q == $past(e0_code)) && (e2_q == $past(e1_q)));

    // R2
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e0_code <= CODE_W'(NLVL - 1));

endmodule

bind pid_lut_comp pid_lut_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .valid_o (valid_o),
    .duty_o  (duty_o),
    .e0_code (e0_code),
    .e1_q    (e1_q),
    .e2_q    (e2_q)
);

// File: tb/tb_pid_lut_comp.sv
module tb_pid_lut_comp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic [11:0] therm_i = '0;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_sel = '0;
    logic [3:0]  tbl_addr = '0;
    logic [23:0] tbl_data = '0;
    logic [12:0] duty_o;
    logic        valid_o;

    int checks = 0;
    int errors = 0;

    int mtab [3][13];
    int md, me1, me2;
    int coef [3] = '{2466, -5670, 3798};

    always #4 clk = ~clk;

    pid_lut_comp dut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .therm_i(therm_i),
        .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .duty_o(duty_o), .valid_o(valid_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int popc(input logic [11:0] w);
        int n = 0;
        for (int i = 0; i < 12; i++) n += int'(w[i]);
        return n;
    endfunction

    function automatic int model_step(input logic [11:0] w);
        int e0;
        longint s, q;
        e0 = popc(w);
        s = longint'(md) * 2048 + mtab[0][e0] + mtab[1][me1] + mtab[2][me2];
        q = s >>> 11;
        if (q < 0) q = 0;
        if (q > 8191) q = 8191;
        md  = int'(q);
        me2 = me1;
        me1 = e0;
        return md;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int t = 0; t < 3; t++)
            for (int i = 0; i < 13; i++) mtab[t][i] = coef[t] * (i - 6);
        md = 4096; me1 = 6; me2 = 6;
        chk("R1 duty in reset", int'(duty_o), 4096);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 duty after reset", int'(duty_o), 4096);
        chk("R1 valid after reset", int'(valid_o), 0);
    endtask

    task automatic tbl_write(input int sel, input int addr, input int data);
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = 2'(sel); tbl_addr = 4'(addr); tbl_data = 24'(data);
        @(negedge clk);
        tbl_we = 1'b0;
        if (sel < 3 && addr < 13) mtab[sel][addr] = data;
    endtask

    task automatic pulse(input logic [11:0] w, input string req);
        int exp;
        @(negedge clk);
        therm_i = w; strobe = 1'b1;
        exp = model_step(w);
        @(negedge clk);
        strobe = 1'b0;
        chk({req, " valid"}, int'(valid_o), 1);
        chk({req, " duty"}, int'(duty_o), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();

        // R8 zero-error entries are zero, R1 history at zero code
        pulse(12'h03F, "R8 zero error");
        chk("R8 zero error hold", int'(duty_o), 4096);
        // R8 defaults / R3 taps
        pulse(12'h0FF, "R8 code8");
        pulse(12'h00F, "R3 code4");
        pulse(12'h03F, "R3 code6");
        // R6 valid drops and duty holds
        @(negedge clk);
        chk("R6 valid low", int'(valid_o), 0);
        therm_i = 12'hFFF;
        repeat (3) @(negedge clk);
        chk("R6 duty hold", int'(duty_o), md);
        // R2 non-contiguous words
        pulse(12'hA5A, "R2 scattered six");
        pulse(12'h801, "R2 scattered two");
        pulse(12'hFFF, "R2 all set");
        pulse(12'h000, "R2 none set");

        // R4 one LSB below an integer
        do_reset();
        tbl_write(0, 7, -1);
        pulse(12'h07F, "R4 floor");
        chk("R4 floor value", int'(duty_o), 4095);

        // R5 upper clamp and recovery
        do_reset();
        tbl_write(0, 12, 24'h7FFFFF);
        tbl_write(1, 12, 0);
        tbl_write(2, 12, 0);
        for (int k = 0; k < 4; k++) pulse(12'hFFF, "R5 upper clamp");
        chk("R5 at max", int'(duty_o), 8191);
        tbl_write(0, 0, -2048 * 5);
        tbl_write(1, 12, 0);
        pulse(12'h000, "R5 stored clamp");
        // R5 lower clamp
        tbl_write(0, 0, -8388608);
        tbl_write(1, 0, 0);
        tbl_write(2, 0, 0);
        for (int k = 0; k < 5; k++) pulse(12'h000, "R5 lower clamp");
        chk("R5 at min", int'(duty_o), 0);
        tbl_write(0, 6, 2048 * 3);
        pulse(12'h111, "R5 from min");

        // R7 reload and ignored writes
        do_reset();
        tbl_write(3, 6, 24'h7FFFFF);
        tbl_write(0, 13, 24'h7FFFFF);
        tbl_write(1, 15, 24'h7FFFFF);
        pulse(12'h03F, "R7 ignored writes");
        tbl_write(1, 6, 2048 * 10);
        pulse(12'h03F, "R7 reload tap B");
        tbl_write(2, 6, -2048 * 4 - 7);
        pulse(12'h03F, "R7 reload tap C");

        // R3 random
        do_reset();
        for (int n = 0; n < 300; n++) begin
            if ($urandom_range(0, 4) == 0)
                tbl_write(int'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
                          int'($urandom_range(0, 16000)) - 8000);
            pulse(12'($urandom), "R3 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule